// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an asynchronous 64K x 8 static RAM. The host raises a one-cycle request with a read/write flag, a 16-bit address and, for writes, a data byte. The controller then produces the strobe sequence the RAM expects and reports completion with a one-clock done pulse. For a read, the captured byte is returned on the host read-data port. The RAM has an active-low and an active-high chip select, an active-low output enable, an active-low write enable and one shared data bus. The controller brings that bus out as separate data-out, data-in and drive-enable signals.

Every wait is computed at elaboration time from nanosecond-scale timing parameters, given in picoseconds, and from the clock period. A wait is the ceiling of the time over the period, and never less than one cycle. All RAM-side outputs come straight from flops, so no strobe can glitch. During a write, output enable is held inactive. The controller's own bus driver is switched on only after the RAM's output float time has passed, so the bus is never driven from both ends.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is asserted and when idle afterwards, the RAM is deselected (ramCs1N=1, ramCs2=0), ramOeN=1, ramWeN=1, ramDrvEn=0 and hostDone=0.
- R2: A read selects the RAM with ramOeN=0 and ramWeN=1 and holds that for RD = max(ceil(tAA/T), ceil(tOE/T), ceil(tRC/T)) cycles. ramDin is captured at the end of the last of those cycles, and hostRdata then holds the byte stored at the requested address.
- R3: hostDone is high for exactly one clock per accepted access. Counting the accepting edge as edge 0, done is seen after edge RD for a read. For a write, done is seen after edge WE_RISE+1, where WE_RISE = max(1+ceil(tWP/T), ceil(tOHZ/T)+ceil(tDW/T), ceil(tCW/T), ceil(tAW/T), ceil(tWC/T)-1).
- R4: A write stores hostWdata at hostAddr, as captured on the accepting edge. ramOeN stays high whenever ramWeN is low or ramDrvEn is high.
- R5: ramDrvEn rises only after ramOeN has been high for at least ceil(tOHZ/T) cycles. The bus is never driven while the RAM outputs are enabled.
- R6: ramWeN falls one cycle after the address and chip selects are applied, and rises one cycle before the chip selects are released. ramAddr does not change while ramWeN is low.
- R7: The write-enable low pulse lasts at least ceil(tWP/T) cycles. The write data is driven for at least ceil(tDW/T) cycles before ramWeN rises.
- R8: A request raised while an access is in progress is ignored. It produces no done pulse and no RAM write.
- R9: ramWeN is low only while the RAM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, sampled only when idle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 16 | Word address |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Last captured read data |
| hostDone | output | 1 | One-clock completion pulse |
| ramAddr | output | 16 | Address to the RAM |
| ramCs1N | output | 1 | Active-low chip select |
| ramCs2 | output | 1 | Active-high chip select |
| ramOeN | output | 1 | Active-low output enable |
| ramWeN | output | 1 | Active-low write enable |
| ramDout | output | 8 | Data toward the RAM |
| ramDrvEn | output | 1 | Enables the bus driver for ramDout |
| ramDin | input | 8 | Data from the RAM |

## Verification
The bench pairs the controller with a RAM model that returns a corrupted byte until the address and output enable have been steady for the access time. A read wait that is one cycle short therefore shows up as wrong read data. The model only commits a write on the rising edge of write enable, after checking the pulse width and data setup. A shortened strobe or an early data release fails those checks, and a write that never lands turns up as a stale byte on a later read. Back-to-back read-then-write pairs expose a driver that turns on too soon after output enable rises. A request poked in mid-write exposes a controller that queues or restarts on it, because that shows up as an extra done pulse or a corrupted second address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctrl_state_t;

  // Strobes handed from the sequencer to the datapath.
  // load/capture are same-cycle pulses; the pin fields are flop outputs.
  typedef struct packed {
    logic load;
    logic capture;
    logic csOn;
    logic oeOn;
    logic weOn;
    logic drvOn;
  } strobe_t;

  // Wait length in cycles: ceiling of time over period, at least one.
  function automatic int unsigned cyclesFor(input int unsigned timePs,
                                            input int unsigned clkPs);
    int unsigned c;
    c = (timePs + clkPs - 1) / clkPs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_LAST = 13,
  parameter int unsigned DRV_ON  = 5,
  parameter int unsigned WE_RISE = 13,
  parameter int unsigned CNT_W   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  output strobe_t strb,
  output logic    done
);

  localparam logic [CNT_W-1:0] RD_LAST_C = CNT_W'(RD_LAST);
  localparam logic [CNT_W-1:0] DRV_ON_C  = CNT_W'(DRV_ON);
  localparam logic [CNT_W-1:0] WE_RISE_C = CNT_W'(WE_RISE);
  localparam logic [CNT_W-1:0] WE_FALL_C = CNT_W'(1);

  ctrl_state_t     stateQ, stateN;
  logic [CNT_W-1:0] cntQ, cntN;
  logic csQ, oeQ, weQ, drvQ, doneQ;
  logic csN, oeN, weN, drvN, doneN;
  logic accept, captureNow, finishWr;

  assign accept     = (stateQ == ST_IDLE) && req;
  assign captureNow = (stateQ == ST_READ) && (cntQ == RD_LAST_C);
  assign finishWr   = (stateQ == ST_WRITE) && (cntQ == WE_RISE_C);

  // Next state and phase counter
  always_comb begin
    stateN = stateQ;
    cntN   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (req) begin
          stateN = we ? ST_WRITE : ST_READ;
          cntN   = '0;
        end
      end
      ST_READ: begin
        if (captureNow) stateN = ST_IDLE;
        else            cntN   = cntQ + 1'b1;
      end
      ST_WRITE: begin
        if (finishWr) stateN = ST_IDLE;
        else          cntN   = cntQ + 1'b1;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  // Pin levels for the coming cycle, derived from next state and phase
  always_comb begin
    csN = 1'b0;
    oeN = 1'b0;
    weN = 1'b0;
    drvN = 1'b0;
    unique case (stateN)
      ST_READ: begin
        csN = 1'b1;
        oeN = 1'b1;
      end
      ST_WRITE: begin
        csN  = 1'b1;
        weN  = (cntN >= WE_FALL_C) && (cntN < WE_RISE_C);
        drvN = (cntN >= DRV_ON_C);
      end
      default: ;
    endcase
    doneN = captureNow || finishWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      csQ    <= 1'b0;
      oeQ    <= 1'b0;
      weQ    <= 1'b0;
      drvQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateN;
      cntQ   <= cntN;
      csQ    <= csN;
      oeQ    <= oeN;
      weQ    <= weN;
      drvQ   <= drvN;
      doneQ  <= doneN;
    end
  end

  assign strb.load    = accept;
  assign strb.capture = captureNow;
  assign strb.csOn    = csQ;
  assign strb.oeOn    = oeQ;
  assign strb.weOn    = weQ;
  assign strb.drvOn   = drvQ;
  assign done         = doneQ;

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDrvEn,
  input  logic [DATA_W-1:0] ramDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // Address and write data are latched once per access and held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= hostAddr;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdataQ <= '0;
    else if (strb.capture) rdataQ <= ramDin;
  end

  // Pin polarity mapping; every source is a flop
  assign ramAddr   = addrQ;
  assign ramCs1N   = ~strb.csOn;
  assign ramCs2    = strb.csOn;
  assign ramOeN    = ~strb.oeOn;
  assign ramWeN    = ~strb.weOn;
  assign ramDout   = wdataQ;
  assign ramDrvEn  = strb.drvOn;
  assign hostRdata = rdataQ;

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 4000,
  parameter int unsigned T_RC_PS = 55000,
  parameter int unsigned T_AA_PS = 55000,
  parameter int unsigned T_OE_PS = 30000,
  parameter int unsigned T_WC_PS = 55000,
  parameter int unsigned T_CW_PS = 50000,
  parameter int unsigned T_AW_PS = 50000,
  parameter int unsigned T_WP_PS = 40000,
  parameter int unsigned T_DW_PS = 30000,
  parameter int unsigned T_OHZ_PS = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDrvEn,
  input  logic [DATA_W-1:0] ramDin
);

  localparam int unsigned RC_CYC  = cyclesFor(T_RC_PS, CLK_PS);
  localparam int unsigned AA_CYC  = cyclesFor(T_AA_PS, CLK_PS);
  localparam int unsigned OE_CYC  = cyclesFor(T_OE_PS, CLK_PS);
  localparam int unsigned WC_CYC  = cyclesFor(T_WC_PS, CLK_PS);
  localparam int unsigned CW_CYC  = cyclesFor(T_CW_PS, CLK_PS);
  localparam int unsigned AW_CYC  = cyclesFor(T_AW_PS, CLK_PS);
  localparam int unsigned WP_CYC  = cyclesFor(T_WP_PS, CLK_PS);
  localparam int unsigned DW_CYC  = cyclesFor(T_DW_PS, CLK_PS);
  localparam int unsigned OHZ_CYC = cyclesFor(T_OHZ_PS, CLK_PS);

  // Read: phases 0..RD_LAST with outputs enabled, capture at the end
  localparam int unsigned RD_LAST = maxOf(maxOf(AA_CYC, OE_CYC), RC_CYC) - 1;
  // Write: driver on at phase DRV_ON, strobe high again at phase WE_RISE
  localparam int unsigned DRV_ON  = OHZ_CYC;
  localparam int unsigned WE_RISE = maxOf(maxOf(1 + WP_CYC, DRV_ON + DW_CYC),
                                          maxOf(maxOf(CW_CYC, AW_CYC), WC_CYC - 1));
  localparam int unsigned CNT_W   = $clog2(maxOf(RD_LAST, WE_RISE) + 2);

  strobe_t strb;

  sram_ctrl_fsm #(
    .RD_LAST(RD_LAST),
    .DRV_ON (DRV_ON),
    .WE_RISE(WE_RISE),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk (clk),
    .rstN(rstN),
    .req (hostReq),
    .we  (hostWe),
    .strb(strb),
    .done(hostDone)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .ramAddr  (ramAddr),
    .ramCs1N  (ramCs1N),
    .ramCs2   (ramCs2),
    .ramOeN   (ramOeN),
    .ramWeN   (ramWeN),
    .ramDout  (ramDout),
    .ramDrvEn (ramDrvEn),
    .ramDin   (ramDin)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OHZ_CYC = 5,
  parameter int unsigned WP_CYC  = 10,
  parameter int unsigned DW_CYC  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramCs1N,
  input logic              ramCs2,
  input logic              ramOeN,
  input logic              ramWeN,
  input logic              ramDrvEn,
  input logic              hostDone
);

  localparam logic [7:0] OHZ_C = 8'(OHZ_CYC);
  localparam logic [7:0] WP_C  = 8'(WP_CYC);
  localparam logic [7:0] DW_C  = 8'(DW_CYC);

  logic [7:0] oeHighCnt, weLowCnt, drvCnt;
  logic       selected;

  assign selected = !ramCs1N && ramCs2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeHighCnt <= '0;
      weLowCnt  <= '0;
      drvCnt    <= '0;
    end else begin
      oeHighCnt <= !ramOeN ? 8'd0 : ((oeHighCnt == 8'hFF) ? oeHighCnt : oeHighCnt + 8'd1);
      weLowCnt  <= ramWeN  ? 8'd0 : ((weLowCnt  == 8'hFF) ? weLowCnt  : weLowCnt  + 8'd1);
      drvCnt    <= !ramDrvEn ? 8'd0 : ((drvCnt  == 8'hFF) ? drvCnt    : drvCnt    + 8'd1);
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN || ramDrvEn) |-> ramOeN);

  assert_bus_turnaround_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramDrvEn |-> (oeHighCnt >= OHZ_C));

  assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN && $past(!ramWeN)) |-> $stable(ramAddr));

  assert_strobe_end_selected_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> (selected && $stable(ramAddr)));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> (weLowCnt >= WP_C));

  assert_data_setup_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> (ramDrvEn && drvCnt >= DW_C));

  assert_we_needs_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> selected);

endmodule

bind sram_access_ctrl sram_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .OHZ_CYC(OHZ_CYC),
  .WP_CYC (WP_CYC),
  .DW_CYC (DW_CYC)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .ramAddr (ramAddr),
  .ramCs1N (ramCs1N),
  .ramCs2  (ramCs2),
  .ramOeN  (ramOeN),
  .ramWeN  (ramWeN),
  .ramDrvEn(ramDrvEn),
  .hostDone(hostDone)
);

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

  // 250 MHz: 4 ns period, timings below in ns
  localparam int CLK_NS = 4;
  localparam int T_RC = 55, T_AA = 55, T_OE = 30, T_WC = 55, T_CW = 50;
  localparam int T_AW = 50, T_WP = 40, T_DW = 30, T_OHZ = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        hostDone;
  logic [15:0] ramAddr;
  logic        ramCs1N, ramCs2, ramOeN, ramWeN, ramDrvEn;
  logic [7:0]  ramDout;
  logic [7:0]  ramDin = '0;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostDone(hostDone), .ramAddr(ramAddr), .ramCs1N(ramCs1N), .ramCs2(ramCs2),
    .ramOeN(ramOeN), .ramWeN(ramWeN), .ramDout(ramDout), .ramDrvEn(ramDrvEn),
    .ramDin(ramDin)
  );

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Cycles from the accepting edge (inclusive) to the negedge where done shows
  function automatic int expLatency(input bit isWr);
    int weRise;
    if (!isWr) return imax(imax(cyc(T_AA), cyc(T_OE)), cyc(T_RC)) + 1;
    weRise = imax(imax(1 + cyc(T_WP), cyc(T_OHZ) + cyc(T_DW)),
                  imax(imax(cyc(T_CW), cyc(T_AW)), cyc(T_WC) - 1));
    return weRise + 2;
  endfunction

  function automatic logic [7:0] initVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // RAM model contents and the bench's independent expectation
  logic [7:0] ramMem [int unsigned];
  logic [7:0] expMem [int unsigned];

  function automatic logic [7:0] ramRead(input logic [15:0] a);
    return ramMem.exists(int'(a)) ? ramMem[int'(a)] : initVal(a);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : initVal(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- asynchronous RAM model ----------------
  int         weAge = 0, drvAge = 0, oeAge = 0, rdAge = 0;
  logic       prevWeLow = 1'b0, prevRdOk = 1'b0;
  logic [15:0] prevAddr = '0;

  always @(negedge clk) begin
    logic sel, rdOk;
    if (rstN) begin
      sel  = !ramCs1N && ramCs2;
      rdOk = sel && !ramOeN && ramWeN;
      if (ramDrvEn && sel && !ramOeN) check("R5 contention", 1, 0);
      if (ramDrvEn && oeAge < cyc(T_OHZ)) check("R5 turnaround", oeAge, cyc(T_OHZ));
      if (!ramWeN && !sel) check("R9 strobe while deselected", 1, 0);
      if (!ramWeN && !ramOeN) check("R4 oe low in write", 1, 0);
      if (prevWeLow && !ramWeN && ramAddr != prevAddr) check("R6 addr moved", ramAddr, prevAddr);
      if (prevWeLow && !(sel && !ramWeN)) begin
        // end of write: commit and check strobe timing
        if (weAge * CLK_NS < T_WP) check("R7 pulse width", weAge, cyc(T_WP));
        if (drvAge * CLK_NS < T_DW) check("R7 data setup", drvAge, cyc(T_DW));
        if (!sel) check("R6 select released with strobe", 0, 1);
        ramMem[int'(prevAddr)] = ramDrvEn ? ramDout : 8'hxx;
      end
      weAge  = (sel && !ramWeN) ? weAge + 1 : 0;
      drvAge = ramDrvEn ? drvAge + 1 : 0;
      oeAge  = ramOeN ? ((oeAge > 1000) ? oeAge : oeAge + 1) : 0;
      rdAge  = rdOk ? ((prevRdOk && ramAddr == prevAddr) ? rdAge + 1 : 1) : 0;
      ramDin = (rdOk && rdAge * CLK_NS >= imax(T_AA, T_OE)) ? ramRead(ramAddr)
                                                            : ~ramRead(ramAddr);
      prevWeLow = sel && !ramWeN;
      prevRdOk  = rdOk;
      prevAddr  = ramAddr;
    end
  end

  // ---------------- host side ----------------
  task automatic doAccess(input bit isWr, input logic [15:0] a, input logic [7:0] d,
                          input bit poke, input logic [15:0] pokeAddr);
    int  k = 0;
    bit  seen = 0;
    hostReq = 1'b1; hostWe = isWr; hostAddr = a; hostWdata = d;
    while (!seen && k < 64) begin
      @(posedge clk); @(negedge clk); k++;
      if (k == 1) begin hostReq = 1'b0; hostAddr = ~a; hostWdata = ~d; end
      if (poke && k == 3) begin
        hostReq = 1'b1; hostWe = 1'b1; hostAddr = pokeAddr; hostWdata = 8'hA5;
      end
      if (poke && k == 4) hostReq = 1'b0;
      if (hostDone) seen = 1;
    end
    check(isWr ? "R3 write latency" : "R3 read latency", k, expLatency(isWr));
    if (!isWr) check("R2 read data", hostRdata, expRead(a));
    else begin
      expMem[int'(a)] = d;
      check("R4 stored byte", ramRead(a), d);
    end
    @(posedge clk); @(negedge clk);
    check("R3 done single pulse", hostDone, 0);
    check("R1 idle after access", {ramCs1N, ramCs2, ramOeN, ramWeN, ramDrvEn}, 5'b10110);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 reset state", {ramCs1N, ramCs2, ramOeN, ramWeN, ramDrvEn, hostDone}, 6'b101100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {ramCs1N, ramCs2, ramOeN, ramWeN, ramDrvEn, hostDone}, 6'b101100);

    // Directed corners
    doAccess(1'b0, 16'h1234, 8'h00, 0, '0);                // R2 unwritten location
    doAccess(1'b1, 16'h0000, 8'hFF, 0, '0);                // R4 lowest address
    doAccess(1'b0, 16'h0000, 8'h00, 0, '0);
    doAccess(1'b1, 16'hFFFF, 8'h00, 0, '0);                // R4 highest address
    doAccess(1'b0, 16'hFFFF, 8'h00, 0, '0);
    doAccess(1'b1, 16'h0000, 8'h81, 0, '0);                // R5 write right after a read
    doAccess(1'b1, 16'h0040, 8'h3C, 1, 16'h0041);          // R8 poke during write
    repeat (4) begin
      @(negedge clk);
      check("R8 no stray done", hostDone, 0);
    end
    doAccess(1'b0, 16'h0041, 8'h00, 0, '0);                // R8 poked address untouched
    doAccess(1'b0, 16'h0040, 8'h00, 0, '0);
    doAccess(1'b0, 16'h0050, 8'h00, 1, 16'h0051);          // R8 poke during read
    doAccess(1'b0, 16'h0051, 8'h00, 0, '0);

    // Constrained random traffic over a small address pool
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      int gap;
      a = {$urandom_range(0, 1) ? 8'hC0 : 8'h00, 5'd0, 3'($urandom_range(0, 7))};
      doAccess(1'($urandom_range(0, 1)), a, 8'($urandom), 0, '0);
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule